// File: doc/BRIEF.md
# Dual-Channel Simultaneous ADC Read Controller

This block sits on the host side of an analog-to-digital converter package that holds two converters which sample at the same instant and return their results over two serial data lines that share one serial clock. For each request the controller runs one complete conversion cycle. It drives the active-low conversion-start line low for a fixed number of cycles, which starts the conversion. It then waits for the converter's busy line to fall, or for a conversion timeout to run out. After that it pulls chip select low, generates the serial clock from the system clock, and shifts both data lines in on every rising serial-clock edge.

A normal frame reads one 14-bit result from each line. An extended frame keeps chip select low for longer. After its own result, each line carries the other converter's result and then two padding bits, which the controller checks and throws away. At the end of the frame the controller releases chip select and presents two results (normal) or four results (extended) together for one cycle of a valid strobe. It then returns to idle.

After reset the controller holds off every conversion until a reference power-up interval has passed. On request it also brings the converter out of shutdown: it drives a low pulse and then a rising edge on the conversion-start line, and it waits a power-up time before it accepts the next start.

States: `S_PWRUP` (reset power-up wait) → `S_IDLE`. From `S_IDLE`, a wake request leads to `S_WAKE_LO` → `S_WAKE_WAIT` → `S_IDLE`. A start request leads to `S_CNV` → `S_WAIT` (busy fall or timeout) → `S_SHIFT` (serial frame) → `S_DONE` (results out) → `S_IDLE`.

Top module: `duo_adc_reader`

## Requirements
- R1: While reset is applied and afterwards, `cnv_n` and `cs_n` are high, `sclk` is low and `res_valid` is low. No falling edge appears on `cnv_n` until PWRUP_CYC cycles after reset release, even if `go` is held high throughout.
- R2: A `go` sampled in idle drives `cnv_n` low for exactly CNV_LOW cycles and then high again. `cnv_n` never goes low while `cs_n` is low.
- R3: When `busy` is first sampled low after having been high during the conversion wait, `cs_n` goes low on that same clock edge.
- R4: If `busy` does not fall within BUSY_TMO cycles of `cnv_n` returning high, the read starts anyway and `res_tmo` is 1 along with that frame's results. Otherwise `res_tmo` is 0.
- R5: `sclk` stays low whenever `cs_n` is high. Within a frame, the first rising edge of `sclk` comes CLK_DIV cycles after `cs_n` falls, and each later rising edge comes 2*CLK_DIV cycles after the one before.
- R6: With `ext_mode` low when `go` is accepted, a frame has exactly 14 rising edges of `sclk`. `res_a` holds the 14 bits taken from `sdo_a`, with the first bit received as bit 13 (MSB first), and `res_b` holds the same from `sdo_b`. `res_a_alt` and `res_b_alt` are 0.
- R7: With `ext_mode` high, a frame has exactly 30 rising edges of `sclk`. The first 14 bits of each line fill `res_a` and `res_b`. The next 14 bits of `sdo_a` fill `res_b_alt` and the next 14 bits of `sdo_b` fill `res_a_alt`, each MSB first.
- R8: In an extended frame, `frame_err` is 1 if either of the last two bits on either line is 1. Otherwise it is 0, and it is always 0 after a normal frame.
- R9: `res_valid` is high for exactly one cycle per frame, after `cs_n` has returned high. The result outputs keep their values until the next frame ends.
- R10: A `wake` sampled in idle drives `cnv_n` low for CNV_LOW cycles and then high. The next falling edge of `cnv_n` comes at least WAKE_CYC cycles after that rising edge. `wake` takes priority over a `go` in the same cycle, so that `go` starts no read.
- R11: `go` and `wake` are ignored while a conversion or read is in progress. They cause no extra `cnv_n` edge and leave the frame's results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Request one conversion and read |
| ext_mode | input | 1 | 1 = extended frame with both results per line; sampled with `go` |
| wake | input | 1 | Request exit from converter shutdown |
| busy | input | 1 | Converter busy flag, high during conversion |
| sdo_a | input | 1 | Serial data line A |
| sdo_b | input | 1 | Serial data line B |
| cnv_n | output | 1 | Conversion start, active low, falling edge starts a conversion |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| res_a | output | 14 | Converter A result from line A |
| res_b | output | 14 | Converter B result from line B |
| res_a_alt | output | 14 | Converter A result from line B (extended frame) |
| res_b_alt | output | 14 | Converter B result from line A (extended frame) |
| res_tmo | output | 1 | Frame started on conversion timeout |
| frame_err | output | 1 | Nonzero padding bit in an extended frame |
| res_valid | output | 1 | One-cycle strobe: results are new |

## Verification
The two functions that can land in the same idle cycle are a wake request and a start request. The bench raises `go` and `wake` together in one cycle and then holds `go` high. It judges the outcome at the pins. Only one `cnv_n` pulse of CNV_LOW cycles may appear, `cs_n` must not fall, and the following conversion-start falling edge must come no sooner than WAKE_CYC cycles after the wake pulse's rising edge. A related case raises `go` and `wake` again while a read is running, and the bench checks that no extra `cnv_n` edge appears and that the results match the data the converter model sent.

// File: rtl/duo_adc_pkg.sv
package duo_adc_pkg;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_IDLE,
        S_CNV,
        S_WAIT,
        S_SHIFT,
        S_DONE,
        S_WAKE_LO,
        S_WAKE_WAIT
    } rd_state_t;

endpackage

// File: rtl/duo_adc_sclk.sv
module duo_adc_sclk #(
    parameter int CLK_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] cnt;
    logic          tick;

    assign tick = en && (cnt == DW'(CLK_DIV - 1));
    assign rise = tick && !sclk;
    assign fall = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/duo_adc_lane.sv
module duo_adc_lane #(
    parameter int LEN = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample,
    input  logic           sdi,
    output logic [LEN-1:0] sr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (sample) begin
            sr <= {sr[LEN-2:0], sdi};
        end
    end

endmodule

// File: rtl/duo_adc_fsm.sv
module duo_adc_fsm
    import duo_adc_pkg::*;
#(
    parameter int DATA_W    = 14,
    parameter int PAD_W     = 2,
    parameter int CNV_LOW   = 3,
    parameter int BUSY_TMO  = 200,
    parameter int PWRUP_CYC = 7000,
    parameter int WAKE_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ext_mode,
    input  logic wake,
    input  logic busy,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic cnv_n,
    output logic cs_n,
    output logic sclk_en,
    output logic ext_q,
    output logic tmo_q,
    output logic frame_done
);
    localparam int FRAME_BITS = 2 * DATA_W + PAD_W;
    localparam int BIT_W      = $clog2(FRAME_BITS + 1);
    localparam int MAX_AB     = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
    localparam int MAX_CD     = (BUSY_TMO > CNV_LOW) ? BUSY_TMO : CNV_LOW;
    localparam int CNT_MAX    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    rd_state_t        state, nxt;
    logic [CNT_W-1:0] cyc;
    logic [BIT_W-1:0] bits;
    logic             busy_q;
    logic             busy_fell;
    logic             last_bit;

    assign busy_fell = busy_q && !busy;
    assign last_bit  = sclk_fall &&
                       (bits == (ext_q ? BIT_W'(FRAME_BITS) : BIT_W'(DATA_W)));

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_PWRUP:     if (cyc == CNT_W'(PWRUP_CYC - 1)) nxt = S_IDLE;
            S_IDLE:      if (wake) nxt = S_WAKE_LO;
                         else if (go) nxt = S_CNV;
            S_CNV:       if (cyc == CNT_W'(CNV_LOW - 1)) nxt = S_WAIT;
            S_WAIT:      if (busy_fell || cyc == CNT_W'(BUSY_TMO - 1)) nxt = S_SHIFT;
            S_SHIFT:     if (last_bit) nxt = S_DONE;
            S_DONE:      nxt = S_IDLE;
            S_WAKE_LO:   if (cyc == CNT_W'(CNV_LOW - 1)) nxt = S_WAKE_WAIT;
            S_WAKE_WAIT: if (cyc == CNT_W'(WAKE_CYC - 1)) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_PWRUP;
            cyc    <= '0;
            bits   <= '0;
            busy_q <= 1'b0;
            ext_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            state  <= nxt;
            busy_q <= busy;
            cyc    <= (nxt != state) ? '0 : cyc + 1'b1;
            if (state != S_SHIFT)
                bits <= '0;
            else if (sclk_rise)
                bits <= bits + 1'b1;
            if (state == S_IDLE && nxt == S_CNV)
                ext_q <= ext_mode;
            if (state == S_WAIT && nxt == S_SHIFT)
                tmo_q <= !busy_fell;
        end
    end

    // outputs decoded from the state
    always_comb begin
        cnv_n      = !(state == S_CNV || state == S_WAKE_LO);
        cs_n       = (state != S_SHIFT);
        sclk_en    = (state == S_SHIFT);
        frame_done = (state == S_DONE);
    end

    // R3
    busy_to_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && busy_fell) |=> !cs_n);

    // R2
    start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> cnv_n);

endmodule

// File: rtl/duo_adc_reader.sv
module duo_adc_reader #(
    parameter int DATA_W    = 14,
    parameter int PAD_W     = 2,
    parameter int CLK_DIV   = 3,
    parameter int CNV_LOW   = 3,
    parameter int BUSY_TMO  = 200,
    parameter int PWRUP_CYC = 7000,
    parameter int WAKE_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              ext_mode,
    input  logic              wake,
    input  logic              busy,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic              cnv_n,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_b,
    output logic [DATA_W-1:0] res_a_alt,
    output logic [DATA_W-1:0] res_b_alt,
    output logic              res_tmo,
    output logic              frame_err,
    output logic              res_valid
);
    localparam int LEN = 2 * DATA_W + PAD_W;

    logic           sclk_en, sclk_rise, sclk_fall;
    logic           ext_q, tmo_q, frame_done;
    logic [1:0]     sdo_vec;
    logic [LEN-1:0] sr [2];

    assign sdo_vec = {sdo_b, sdo_a};

    duo_adc_fsm #(
        .DATA_W(DATA_W), .PAD_W(PAD_W), .CNV_LOW(CNV_LOW),
        .BUSY_TMO(BUSY_TMO), .PWRUP_CYC(PWRUP_CYC), .WAKE_CYC(WAKE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .ext_mode(ext_mode),
        .wake(wake), .busy(busy), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .cnv_n(cnv_n), .cs_n(cs_n),
        .sclk_en(sclk_en), .ext_q(ext_q), .tmo_q(tmo_q),
        .frame_done(frame_done)
    );

    duo_adc_sclk #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk(clk), .rst_n(rst_n), .en(sclk_en),
        .sclk(sclk), .rise(sclk_rise), .fall(sclk_fall)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        duo_adc_lane #(.LEN(LEN)) u_lane (
            .clk(clk), .rst_n(rst_n), .sample(sclk_rise),
            .sdi(sdo_vec[g]), .sr(sr[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_a     <= '0;
            res_b     <= '0;
            res_a_alt <= '0;
            res_b_alt <= '0;
            res_tmo   <= 1'b0;
            frame_err <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= frame_done;
            if (frame_done) begin
                res_tmo <= tmo_q;
                if (ext_q) begin
                    res_a     <= sr[0][LEN-1 -: DATA_W];
                    res_b     <= sr[1][LEN-1 -: DATA_W];
                    res_b_alt <= sr[0][PAD_W +: DATA_W];
                    res_a_alt <= sr[1][PAD_W +: DATA_W];
                    frame_err <= (|sr[0][PAD_W-1:0]) || (|sr[1][PAD_W-1:0]);
                end else begin
                    res_a     <= sr[0][DATA_W-1:0];
                    res_b     <= sr[1][DATA_W-1:0];
                    res_a_alt <= '0;
                    res_b_alt <= '0;
                    frame_err <= 1'b0;
                end
            end
        end
    end

    // R5
    idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    sample_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> !cs_n);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    valid_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cs_n);

endmodule

// File: tb/duo_adc_reader_test.sv
module duo_adc_reader_test;
    localparam int W    = 14;
    localparam int DIV  = 3;
    localparam int CLOW = 3;
    localparam int TMO  = 40;
    localparam int PWR  = 400;
    localparam int WK   = 80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic go = 1'b0, ext_mode = 1'b0, wake = 1'b0, busy = 1'b0;
    logic sdo_a = 1'b0, sdo_b = 1'b0;
    logic cnv_n, cs_n, sclk, res_tmo, frame_err, res_valid;
    logic [W-1:0] res_a, res_b, res_a_alt, res_b_alt;

    always #5 clk = ~clk;

    duo_adc_reader #(.DATA_W(W), .PAD_W(2), .CLK_DIV(DIV), .CNV_LOW(CLOW),
                     .BUSY_TMO(TMO), .PWRUP_CYC(PWR), .WAKE_CYC(WK)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .ext_mode(ext_mode), .wake(wake),
        .busy(busy), .sdo_a(sdo_a), .sdo_b(sdo_b), .cnv_n(cnv_n), .cs_n(cs_n),
        .sclk(sclk), .res_a(res_a), .res_b(res_b), .res_a_alt(res_a_alt),
        .res_b_alt(res_b_alt), .res_tmo(res_tmo), .frame_err(frame_err),
        .res_valid(res_valid)
    );

    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // converter model: frame per line = own word, other word, padding
    logic [2*W+1:0] fa = '0, fb = '0;
    int k = 0;
    always @(negedge cs_n) begin
        k = 0; sdo_a = fa[2*W+1]; sdo_b = fb[2*W+1];
    end
    always @(negedge sclk) if (!cs_n) begin
        k++;
        sdo_a = (k < 2*W+2) ? fa[2*W+1-k] : 1'b0;
        sdo_b = (k < 2*W+2) ? fb[2*W+1-k] : 1'b0;
    end

    // busy model
    bit busy_arm = 1'b0, busy_never = 1'b0, follow_ok = 1'b0;
    int busy_len = 6;
    always @(negedge cnv_n) if (busy_arm && !busy_never) begin
        follow_ok = 1'b0;
        repeat (2) @(negedge clk);
        busy = 1'b1;
        repeat (busy_len) @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        follow_ok = !cs_n;
    end

    // pin monitor
    int ncyc = 0, cnv_falls = 0, cs_falls = 0, rises = 0, since = 0, per_bad = 0;
    int cnv_bad = 0, lo_len = 0, last_rise = 0, last_gap = 0, first_fall = -1, valids = 0;
    logic p_cnv = 1'b1, p_cs = 1'b1, p_sclk = 1'b0;
    always @(negedge clk) if (rst_n) begin
        ncyc++; since++;
        if (p_cnv && !cnv_n) begin
            cnv_falls++; lo_len = 0; last_gap = ncyc - last_rise;
            if (first_fall < 0) first_fall = ncyc;
        end
        if (!cnv_n) lo_len++;
        if (!p_cnv && cnv_n) begin
            if (lo_len != CLOW) cnv_bad++;
            last_rise = ncyc;
        end
        if (p_cs && !cs_n) begin cs_falls++; rises = 0; since = 0; end
        if (!p_sclk && sclk && !cs_n) begin
            if (since != ((rises == 0) ? DIV : 2*DIV)) per_bad++;
            rises++; since = 0;
        end
        if (res_valid) valids++;
        p_cnv = cnv_n; p_cs = cs_n; p_sclk = sclk;
    end

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (res_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic do_frame(input bit ext, input bit never, input logic [W-1:0] wa,
                            input logic [W-1:0] wb, input logic [1:0] pa,
                            input logic [1:0] pb, input int blen);
        bit ok;
        logic [W-1:0] ha;
        fa = {wa, wb, pa}; fb = {wb, wa, pb};
        busy_arm = 1'b1; busy_never = never; busy_len = blen; per_bad = 0; cnv_bad = 0;
        @(negedge clk); go = 1'b1; ext_mode = ext;
        @(negedge clk); go = 1'b0; ext_mode = $urandom_range(0, 1);
        wait_valid(ok);
        chk("R9", "valid seen", ok, 1);
        chk(ext ? "R7" : "R6", "res_a", res_a, wa);
        chk(ext ? "R7" : "R6", "res_b", res_b, wb);
        chk(ext ? "R7" : "R6", "res_a_alt", res_a_alt, ext ? wa : 0);
        chk(ext ? "R7" : "R6", "res_b_alt", res_b_alt, ext ? wb : 0);
        chk("R8", "frame_err", frame_err, (ext && (pa != 0 || pb != 0)) ? 1 : 0);
        chk("R4", "res_tmo", res_tmo, never ? 1 : 0);
        chk(ext ? "R7" : "R6", "sclk rises", rises, ext ? 2*W+2 : W);
        chk("R5", "sclk spacing faults", per_bad, 0);
        chk("R2", "cnv_n low width faults", cnv_bad, 0);
        chk("R9", "cs_n high at valid", cs_n, 1);
        if (!never) chk("R3", "cs_n low after busy fall", follow_ok, 1);
        ha = res_a;
        @(negedge clk);
        chk("R9", "valid one cycle", res_valid, 0);
        chk("R9", "result held", res_a, ha);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        int c0, s0;
        bit ok;
        void'($urandom(32'd4242));
        go = 1'b1;   // held through power-up: R1
        repeat (3) @(negedge clk);
        chk("R1", "cnv_n in reset", cnv_n, 1);
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "sclk in reset", sclk, 0);
        chk("R1", "res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        busy_arm = 1'b1;
        fa = '0; fb = '0;
        while (cnv_falls == 0 && ncyc < PWR + 50) @(negedge clk);
        go = 1'b0;
        chk("R1", "first start not before power-up", (first_fall >= PWR) ? 1 : 0, 1);
        chk("R1", "first start soon after power-up", (first_fall <= PWR + 3) ? 1 : 0, 1);
        wait_valid(ok);
        repeat (3) @(negedge clk);

        // directed corners
        do_frame(1'b0, 1'b0, 14'h3FFF, 14'h0000, 2'b11, 2'b11, 6);  // R6, pads ignored
        do_frame(1'b1, 1'b0, 14'h2A5C, 14'h1234, 2'b00, 2'b00, 5);  // R7 clean
        do_frame(1'b1, 1'b0, 14'h0001, 14'h2000, 2'b00, 2'b01, 8);  // R8 pad on B
        do_frame(1'b1, 1'b0, 14'h3FFF, 14'h3FFF, 2'b10, 2'b00, 4);  // R8 pad on A
        do_frame(1'b0, 1'b1, 14'h1555, 14'h2AAA, 2'b00, 2'b00, 0);  // R4 timeout
        do_frame(1'b1, 1'b1, 14'h0F0F, 14'h30F0, 2'b00, 2'b00, 0);  // R4 timeout, ext

        // R11: go and wake during a read are ignored
        fa = {14'h1111, 14'h2222, 2'b00}; fb = {14'h2222, 14'h1111, 2'b00};
        busy_never = 1'b0; busy_len = 5;
        c0 = cnv_falls;
        @(negedge clk); go = 1'b1; ext_mode = 1'b1;
        @(negedge clk); go = 1'b0;
        while (cs_n) @(negedge clk);
        go = 1'b1; wake = 1'b1;
        @(negedge clk); go = 1'b0; wake = 1'b0;
        wait_valid(ok);
        chk("R11", "results after ignored requests", res_b_alt, 14'h2222);
        repeat (WK) @(negedge clk);
        chk("R11", "no extra cnv_n edge", cnv_falls - c0, 1);

        // R10: wake and go in the same idle cycle
        busy_arm = 1'b0;
        c0 = cnv_falls; s0 = cs_falls; cnv_bad = 0;
        @(negedge clk); go = 1'b1; wake = 1'b1;
        @(negedge clk); wake = 1'b0; go = 1'b0;
        repeat (4) @(negedge clk);
        busy_arm = 1'b1; busy_never = 1'b0; busy_len = 5;
        go = 1'b1;
        while (cnv_falls < c0 + 2 && ncyc < 190000) @(negedge clk);
        chk("R10", "cs_n untouched by wake", (cs_falls == s0) ? 1 : 0, 1);
        go = 1'b0;
        chk("R10", "start after wake respects power-up", (last_gap >= WK) ? 1 : 0, 1);
        chk("R10", "wake pulse width faults", cnv_bad, 0);
        wait_valid(ok);
        repeat (3) @(negedge clk);

        // constrained random frames
        for (int i = 0; i < 16; i++) begin
            bit e;
            logic [1:0] pa, pb;
            e  = $urandom_range(0, 1);
            pa = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            pb = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            do_frame(e, ($urandom_range(0, 7) == 0), 14'($urandom), 14'($urandom),
                     pa, pb, $urandom_range(3, 20));
        end

        finish_run();
    end

endmodule